// File: doc/BRIEF.md
# Quadword Memory Controller with Byte Merge

This block is a memory controller on a shared 32-bit beat bus. Its storage is organised as 64-bit words. A bus master opens a transaction with one address beat. For a write, it then sends two 32-bit data beats: the lower half of the word first, then the upper half. For a read, the controller returns the two halves on its own read-data output over two cycles.

Each write data beat carries four byte enables, so the two beats together give an eight-bit lane mask for the stored word. When all eight lanes are enabled, the word is written straight into storage. When only some lanes are enabled, the controller first fetches the stored word, replaces only the enabled bytes and writes the result back. During this extra sequence it holds its ready signal low.

A beat that breaks the address-then-data pattern is refused with a one-cycle error pulse.

Top module: `qw_mem_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `bus_ready` is 1, `rd_vld` is 0 and `err_vld` is 0.
- R2: A beat is taken on a rising edge where both `beat_vld` and `bus_ready` are high. A write is taken as three beats:
  - an address beat (`beat_addr`=1, `beat_wr`=1);
  - a data beat holding bytes 0..3 of the word;
  - a data beat holding bytes 4..7.
  
  Byte b of a word occupies bits 8b+7:8b.
- R3: A read is an address beat with `beat_wr`=0. After it is taken, `bus_ready` is low for the next two cycles.
  - From the second edge after the address is taken, `rd_vld` is high for exactly two cycles.
  - `rd_data` carries bytes 0..3 in the first of these cycles and bytes 4..7 in the second.
- R4: On an address beat, `beat_data[IDX_W:1]` selects the storage word, where IDX_W = log2(DEPTH). Bits 31:30, bit 0 and all index bits above IDX_W are ignored, so addresses wrap modulo DEPTH.
- R5: On data beat n (0 = first, 1 = second), `beat_be[j]` enables byte 4n+j. A byte whose enable is 0 keeps its stored value.
- R6: When all eight enables are set, `bus_ready` stays high, and the next address beat can be taken on the edge right after the second data beat.
- R7: When any enable is clear, including the case where every enable is 0, `bus_ready` is low for exactly two cycles after the second data beat is taken.
- R8: `err_vld` is high for one cycle, starting on the edge after the offending beat, when either of these beats is taken:
  - a data beat with no transaction open;
  - an address beat while write data is still awaited.
  
  The open write is dropped, the offending beat is discarded, and storage is unchanged.
- R9: Beats offered while `bus_ready` is low are ignored. They raise no error and change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_vld | input | 1 | A beat is offered |
| beat_addr | input | 1 | 1 = address beat, 0 = data beat |
| beat_wr | input | 1 | On an address beat: 1 = write, 0 = read |
| beat_data | input | 32 | Address or write data |
| beat_be | input | 4 | Byte enables of a write data beat |
| bus_ready | output | 1 | Controller can take a beat |
| rd_vld | output | 1 | Read half is on `rd_data` |
| rd_data | output | 32 | Read data half |
| err_vld | output | 1 | One-cycle error response |

## Verification
Let k be the edge on which a read address is taken. The bench samples on falling edges:
- the falling edge after k, expecting ready low;
- the falling edge after k+1, expecting the lower half with `rd_vld`;
- the falling edge after k+2, expecting the upper half with ready high again.

Let k be the edge on which the second write beat is taken. After a full write, ready is already high at the falling edge after k. After a partial write, ready is low at the falling edges after k and k+1 and high after k+2.

An error pulse is looked for at the falling edge after the offending beat, and it must be gone one cycle later. Stored contents are checked only through later reads against a byte-level reference array.

// File: rtl/qw_pkg.sv
package qw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI,
    ST_MRD,
    ST_MWB
  } qw_state_e;
endpackage

// File: rtl/qw_store.sv
module qw_store #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qw_merge.sv
module qw_merge #(
  parameter int WORD_W = 64,
  localparam int LANES = WORD_W / 8
) (
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  lane_en,
  output logic [WORD_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = lane_en[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
  end
endmodule

// File: rtl/qw_bus_fsm.sv
module qw_bus_fsm
  import qw_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BEAT_W = 32,
  localparam int WORD_W = 2 * BEAT_W,
  localparam int BE_W   = BEAT_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_vld,
  input  logic              beat_addr,
  input  logic              beat_wr,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic [BE_W-1:0]   beat_be,
  output logic              bus_ready,
  output logic              rd_vld,
  output logic [BEAT_W-1:0] rd_data,
  output logic              err_vld,
  input  logic [WORD_W-1:0] mem_q,
  input  logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] hold_word,
  output logic [2*BE_W-1:0] hold_mask,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_raddr
);
  qw_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [BEAT_W-1:0] lo_q, hi_q;
  logic [BE_W-1:0]   mlo_q, mhi_q;
  logic              take;
  logic              err_d;
  logic              cap_idx, cap_lo, cap_hi;
  logic [IDX_W-1:0]  idx_in;

  assign take   = beat_vld && bus_ready;
  assign idx_in = beat_data[IDX_W:1];

  assign hold_word = {hi_q, lo_q};
  assign hold_mask = {mhi_q, mlo_q};

  always_comb begin
    state_d   = state_q;
    err_d     = 1'b0;
    cap_idx   = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = idx_q;
    mem_wdata = merged;
    mem_re    = 1'b0;
    mem_raddr = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          if (beat_addr) begin
            cap_idx = 1'b1;
            if (beat_wr) begin
              state_d = ST_WLO;
            end else begin
              mem_re    = 1'b1;
              mem_raddr = idx_in;
              state_d   = ST_RLO;
            end
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_WLO: begin
        if (take) begin
          if (beat_addr) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cap_lo  = 1'b1;
            state_d = ST_WHI;
          end
        end
      end
      ST_WHI: begin
        if (take) begin
          if (beat_addr) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (&{beat_be, mlo_q}) begin
            mem_we    = 1'b1;
            mem_wdata = {beat_data, lo_q};
            state_d   = ST_IDLE;
          end else begin
            cap_hi  = 1'b1;
            state_d = ST_MRD;
          end
        end
      end
      ST_RLO: state_d = ST_RHI;
      ST_RHI: state_d = ST_IDLE;
      ST_MRD: begin
        mem_re  = 1'b1;
        state_d = ST_MWB;
      end
      ST_MWB: begin
        mem_we  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bus_ready <= 1'b1;
      rd_vld    <= 1'b0;
      rd_data   <= '0;
      err_vld   <= 1'b0;
      idx_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      mlo_q     <= '0;
      mhi_q     <= '0;
    end else begin
      state_q   <= state_d;
      bus_ready <= (state_d == ST_IDLE) || (state_d == ST_WLO) || (state_d == ST_WHI);
      err_vld   <= err_d;
      if (cap_idx) idx_q <= idx_in;
      if (cap_lo) begin
        lo_q  <= beat_data;
        mlo_q <= beat_be;
      end
      if (cap_hi) begin
        hi_q  <= beat_data;
        mhi_q <= beat_be;
      end
      rd_vld <= 1'b0;
      if (state_q == ST_RLO) begin
        rd_vld  <= 1'b1;
        rd_data <= mem_q[BEAT_W-1:0];
      end else if (state_q == ST_RHI) begin
        rd_vld  <= 1'b1;
        rd_data <= mem_q[WORD_W-1:BEAT_W];
      end
    end
  end
endmodule

// File: rtl/qw_mem_ctrl.sv
module qw_mem_ctrl #(
  parameter int DEPTH  = 256,
  parameter int BEAT_W = 32,
  localparam int WORD_W = 2 * BEAT_W,
  localparam int BE_W   = BEAT_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_vld,
  input  logic              beat_addr,
  input  logic              beat_wr,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic [BE_W-1:0]   beat_be,
  output logic              bus_ready,
  output logic              rd_vld,
  output logic [BEAT_W-1:0] rd_data,
  output logic              err_vld
);
  logic [WORD_W-1:0] mem_q, merged, hold_word, mem_wdata;
  logic [2*BE_W-1:0] hold_mask;
  logic              mem_we, mem_re;
  logic [IDX_W-1:0]  mem_waddr, mem_raddr;

  qw_bus_fsm #(.DEPTH(DEPTH), .BEAT_W(BEAT_W)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .beat_vld  (beat_vld),
    .beat_addr (beat_addr),
    .beat_wr   (beat_wr),
    .beat_data (beat_data),
    .beat_be   (beat_be),
    .bus_ready (bus_ready),
    .rd_vld    (rd_vld),
    .rd_data   (rd_data),
    .err_vld   (err_vld),
    .mem_q     (mem_q),
    .merged    (merged),
    .hold_word (hold_word),
    .hold_mask (hold_mask),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr)
  );

  qw_merge #(.WORD_W(WORD_W)) i_merge (
    .old_word (mem_q),
    .new_word (hold_word),
    .lane_en  (hold_mask),
    .merged   (merged)
  );

  qw_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_q)
  );
endmodule

// File: rtl/qw_mem_ctrl_chk.sv
module qw_mem_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic beat_vld,
  input logic bus_ready,
  input logic rd_vld,
  input logic err_vld,
  input logic mem_we
);
  // R3: read halves come as a pair of consecutive cycles
  p_rd_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_vld) |=> rd_vld);

  // R3: no third read half
  p_rd_end_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && $past(rd_vld)) |=> !rd_vld);

  // R3: ready is low in the cycle of the first read half and the one before it
  p_rd_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_vld) |-> (!bus_ready && !$past(bus_ready)));

  // R8: an error never overlaps a read half
  p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> !rd_vld);

  // R9: an error only follows a beat that was taken
  p_err_taken_r9: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> $past(beat_vld && bus_ready));

  // R2: storage is never written in two consecutive cycles
  p_we_gap_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind qw_mem_ctrl qw_mem_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .beat_vld  (beat_vld),
  .bus_ready (bus_ready),
  .rd_vld    (rd_vld),
  .err_vld   (err_vld),
  .mem_we    (mem_we)
);

// File: tb/test_qw_mem_ctrl.sv
module test_qw_mem_ctrl;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        beat_vld = 1'b0;
  logic        beat_addr = 1'b0;
  logic        beat_wr = 1'b0;
  logic [31:0] beat_data = '0;
  logic [3:0]  beat_be = '0;
  logic        bus_ready, rd_vld, err_vld;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [DEPTH*8];

  always #2 clk = ~clk;

  qw_mem_ctrl #(.DEPTH(DEPTH)) i_qw_mem_ctrl (
    .clk(clk), .rst(rst), .beat_vld(beat_vld), .beat_addr(beat_addr),
    .beat_wr(beat_wr), .beat_data(beat_data), .beat_be(beat_be),
    .bus_ready(bus_ready), .rd_vld(rd_vld), .rd_data(rd_data), .err_vld(err_vld)
  );

  function automatic int word_of(input logic [31:0] a);
    return int'(a[8:1]);
  endfunction

  function automatic logic [63:0] ref_word(input logic [31:0] a);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = ref_mem[word_of(a)*8 + b];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the beat is taken.
  task automatic beat(input logic a, input logic w, input logic [31:0] d, input logic [3:0] be);
    while (!bus_ready) @(negedge clk);
    beat_vld = 1'b1; beat_addr = a; beat_wr = w; beat_data = d; beat_be = be;
    @(negedge clk);
    beat_vld = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] adr, input logic [63:0] d, input logic [7:0] m);
    beat(1'b1, 1'b1, adr, 4'h0);
    beat(1'b0, 1'b0, d[31:0], m[3:0]);
    beat(1'b0, 1'b0, d[63:32], m[7:4]);
    if (&m) begin
      check(bus_ready == 1'b1, "R6 ready after full write", {63'd0, bus_ready}, 64'd1);
    end else begin
      check(bus_ready == 1'b0, "R7 ready low cycle 1", {63'd0, bus_ready}, 64'd0);
      @(negedge clk);
      check(bus_ready == 1'b0, "R7 ready low cycle 2", {63'd0, bus_ready}, 64'd0);
      @(negedge clk);
      check(bus_ready == 1'b1, "R7 ready back", {63'd0, bus_ready}, 64'd1);
    end
    for (int b = 0; b < 8; b++)
      if (m[b]) ref_mem[word_of(adr)*8 + b] = d[8*b +: 8];
  endtask

  task automatic do_read(input logic [31:0] adr, input string tag, input bit poke);
    logic [63:0] e;
    e = ref_word(adr);
    beat(1'b1, 1'b0, adr, 4'h0);
    check(bus_ready == 1'b0, "R3 ready low after read address", {63'd0, bus_ready}, 64'd0);
    if (poke) begin
      beat_vld = 1'b1; beat_addr = 1'b0; beat_data = 32'hdead_beef; beat_be = 4'hf;
    end
    @(negedge clk);
    beat_vld = 1'b0;
    check(rd_vld && rd_data == e[31:0], {tag, " R3 low half"}, {31'd0, rd_vld, rd_data}, {32'd1, e[31:0]});
    check(bus_ready == 1'b0, "R3 ready low second cycle", {63'd0, bus_ready}, 64'd0);
    @(negedge clk);
    check(rd_vld && rd_data == e[63:32], {tag, " R3 high half"}, {31'd0, rd_vld, rd_data}, {32'd1, e[63:32]});
    check(bus_ready == 1'b1, "R3 ready back", {63'd0, bus_ready}, 64'd1);
    if (poke) check(err_vld == 1'b0, "R9 ignored beat gave no error", {63'd0, err_vld}, 64'd0);
    @(negedge clk);
    check(rd_vld == 1'b0, "R3 only two halves", {63'd0, rd_vld}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH*8; i++) ref_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    check(bus_ready && !rd_vld && !err_vld, "R1 state during reset",
          {61'd0, bus_ready, rd_vld, err_vld}, 64'd4);
    rst = 1'b0;
    @(negedge clk);
    check(bus_ready && !rd_vld && !err_vld, "R1 state after reset",
          {61'd0, bus_ready, rd_vld, err_vld}, 64'd4);

    // Clear the words used so that all later reads have known contents (R2, R6)
    for (int i = 0; i < 16; i++) do_write({23'd0, i[7:0], 1'b0}, 64'd0, 8'hff);

    do_write(32'h0000_0004, 64'h8877_6655_4433_2211, 8'hff);
    do_read(32'h0000_0004, "R2 full write", 1'b0);

    // R6: a read address follows a full write directly
    do_write(32'h0000_0006, 64'h0123_4567_89ab_cdef, 8'hff);
    do_read(32'h0000_0006, "R6 back-to-back", 1'b0);

    // R5: partial writes merge per byte
    do_write(32'h0000_0004, 64'hffee_ddcc_bbaa_9988, 8'b1010_0101);
    do_read(32'h0000_0004, "R5 lane merge", 1'b0);
    do_write(32'h0000_0004, 64'hffff_ffff_ffff_ffff, 8'h00);
    do_read(32'h0000_0004, "R7 empty mask", 1'b0);
    do_write(32'h0000_0006, 64'haaaa_aaaa_aaaa_aaaa, 8'h80);
    do_read(32'h0000_0006, "R5 top lane", 1'b0);

    // R4: ignored address bits and wrap-around
    do_write(32'hc000_0205, 64'h5a5a_1234_5678_a5a5, 8'hff);
    do_read(32'h0000_0004, "R4 alias", 1'b0);

    // R8: a data beat with no transaction open
    beat(1'b0, 1'b0, 32'h1111_1111, 4'hf);
    check(err_vld == 1'b1, "R8 stray data error", {63'd0, err_vld}, 64'd1);
    @(negedge clk);
    check(err_vld == 1'b0, "R8 error single cycle", {63'd0, err_vld}, 64'd0);
    // R8: an address beat during write data
    beat(1'b1, 1'b1, 32'h0000_0004, 4'h0);
    beat(1'b0, 1'b0, 32'h7777_7777, 4'hf);
    beat(1'b1, 1'b0, 32'h0000_0006, 4'h0);
    check(err_vld == 1'b1, "R8 address during write error", {63'd0, err_vld}, 64'd1);
    @(negedge clk);
    check(rd_vld == 1'b0 && err_vld == 1'b0, "R8 dropped beat no read",
          {62'd0, rd_vld, err_vld}, 64'd0);
    do_read(32'h0000_0004, "R8 storage unchanged", 1'b0);

    // R9: a beat offered while ready is low
    do_read(32'h0000_0006, "R9 poke during read", 1'b1);

    // Random mix of writes and reads
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [63:0] d;
      logic [7:0]  m;
      a = {$urandom()} & 32'hffff_fe1f;
      a[8:1] = 8'($urandom_range(0, 7));
      d = {$urandom(), $urandom()};
      m = 8'($urandom());
      if ($urandom_range(0, 3) == 0) m = 8'hff;
      if ($urandom_range(0, 2) == 0) do_read(a, "R5 random read", 1'b0);
      else do_write(a, d, m);
    end
    for (int i = 0; i < 8; i++) do_read({23'd0, i[7:0], 1'b0}, "R5 final sweep", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule